// File: doc/BRIEF.md
# Receiver Output Gating and Status Control

This block sits at the electrical edge of a parallel optical receiver. It decides, cycle by cycle, whether the recovered data bus and the forwarded output clock are driven or held at a static low level. Three conditions control this: a synchronous active-low reset, an output enable, and a lock status. Output enable low silences both the data and the clock. Lock low silences only the data, so the clock keeps running while the link is still acquiring.

The block also produces the status flags that the rest of the receiver sees. Frame detect is active high. The lane-12 signal detect is active low. A lock flag comes from a small lock timer that stands in for the PLL: it counts a programmable number of cycles after frame detect rises before it reports lock, and it drops lock on the same edge that frame detect drops.

A test input, detect enable, forces both detect flags to their active states when it is low. The lock timer then starts its acquisition as if a frame were present. The output enable and the analog sense flags come from outside the clock domain and pass through two-flop synchronizers. Every output is a register, so no decode glitch reaches a pin.

Top module: `rxo_gate_ctrl`

## Requirements
- R1: At a clock edge with `rst_n` low, `data_o` and `clk_o` become 0, `frame_det_o` and `lock_o` become 0, and `lane_sd_n_o` becomes 1.
- R2: When `oe_i` is low, `data_o` and `clk_o` are both 0. A fall of `oe_i` takes effect on the third rising edge after the change: two synchronizer stages, then the output register.
- R3: With `oe_i` high and `lock_o` low, `data_o` is 0 and `clk_o` equals the value `clk_i` had at the previous rising edge, so the clock keeps running.
- R4: With `oe_i` high and `lock_o` high, `data_o` equals the value `data_i` had at the previous rising edge (bit i to bit i), and `clk_o` follows `clk_i` in the same way.
- R5: `lock_o` rises exactly `lock_wait_i` rising edges after `frame_det_o` rises (0 means on the same edge), provided frame detect stays high.
- R6: When `frame_sense_i` falls with `det_en_i` high, `frame_det_o` and `lock_o` both go low on the third rising edge after the change.
- R7: While `det_en_i` is low, `frame_det_o` is 1 and `lane_sd_n_o` is 0 whatever the sense inputs are, and the lock timer acquires lock.
- R8: While `det_en_i` is high, `frame_det_o` follows `frame_sense_i` and `lane_sd_n_o` is the inverse of `lane_sense_i`, each after the synchronizer delay.
- R9: `lock_o` is never 1 while `frame_det_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver core clock |
| rst_n | input | 1 | Synchronous active-low reset; holds the logic and silences the outputs |
| oe_i | input | 1 | Output enable, asynchronous; low forces data and clock low |
| frame_sense_i | input | 1 | Analog frame-present flag, asynchronous |
| lane_sense_i | input | 1 | Analog lane-12 signal-present flag, asynchronous |
| det_en_i | input | 1 | Detect enable for test, asynchronous; low forces both detect flags active |
| lock_wait_i | input | CW | Number of cycles from frame detect to lock |
| data_i | input | DW | Decoded, demultiplexed data bus |
| clk_i | input | 1 | Forwarded output clock pattern, sampled each cycle |
| data_o | output | DW | Gated data bus |
| clk_o | output | 1 | Gated output clock |
| frame_det_o | output | 1 | Frame detect, active high |
| lane_sd_n_o | output | 1 | Lane-12 signal detect, active low |
| lock_o | output | 1 | Lock status from the lock timer |

## Verification
The assertions assume that `lock_wait_i` is held steady while frame detect is high. They also assume that the asynchronous control inputs change no more often than once every few cycles, so each change is seen through its synchronizer. The stimulus changes `lock_wait_i` only while frame detect is low, and holds every control combination for at least twenty cycles before it samples the outputs. Edge-latency checks change a single input at a time, leaving the others settled.

// File: rtl/rxo_gate_pkg.sv
// Package: shared defaults and the index map of the synchronized controls.
// Assumes nothing beyond standard SystemVerilog.
package rxo_gate_pkg;

    localparam int unsigned RXO_DATA_W_DEF = 22;
    localparam int unsigned RXO_CNT_W_DEF  = 8;

    // Bit positions of the controls inside the synchronizer vector.
    typedef enum int unsigned {
        SYNC_OE    = 0,
        SYNC_FRAME = 1,
        SYNC_LANE  = 2,
        SYNC_DETEN = 3
    } sync_idx_e;

    localparam int unsigned RXO_SYNC_W = 4;

endpackage

// File: rtl/rxo_sync.sv
// Module: two-flop synchronizer for a vector of independent control bits.
// Assumes each bit is a level that changes slowly compared to clk.
// Reset value of every stage is 0.
module rxo_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    localparam int unsigned LAST = STAGES - 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw level through the chain of flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[b]};
        end

        assign q[b] = chain[LAST];
    end

endmodule

// File: rtl/rxo_status.sv
// Module: detect flag generation with a test override.
// Assumes the inputs are already synchronized to clk.
// det_on is the combinational frame-present decision used by the lock timer.
module rxo_status (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_s,
    input  logic lane_s,
    input  logic deten_s,
    output logic det_on,
    output logic frame_det_q,
    output logic lane_sd_n_q
);

    logic lane_on;

    // Decide the detect levels; a low detect enable forces both active.
    always_comb begin
        det_on  = deten_s ? frame_s : 1'b1;
        lane_on = deten_s ? lane_s  : 1'b1;
    end

    // Register the flags; reset shows both as inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_det_q <= 1'b0;
            lane_sd_n_q <= 1'b1;
        end else begin
            frame_det_q <= det_on;
            lane_sd_n_q <= ~lane_on;
        end
    end

    // R7: a low synchronized detect enable forces both flags active.
    a_r7_forced_active: assert property (@(posedge clk) disable iff (!rst_n)
        !deten_s |=> (frame_det_q && !lane_sd_n_q));

    // R8: with detect enabled the lane flag is the inverse of its sense.
    a_r8_lane_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        (deten_s && lane_s) |=> !lane_sd_n_q);

endmodule

// File: rtl/rxo_lock_timer.sv
// Module: stand-in PLL lock model.
// Counts cycles of frame presence and reports lock once the count reaches
// the programmed wait; clears on the first cycle without frame presence.
// Assumes wait_cycles is stable while det_on is high.
module rxo_lock_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          det_on,
    input  logic [CW-1:0] wait_cycles,
    output logic          lock_q
);

    logic [CW-1:0] cnt_q;
    logic          reached;

    // Compare the running count with the programmed wait.
    always_comb reached = (cnt_q >= wait_cycles);

    // Advance the count while the frame is present, saturating at the wait.
    always_ff @(posedge clk) begin
        if (!rst_n || !det_on) cnt_q <= '0;
        else if (!reached)     cnt_q <= cnt_q + 1'b1;
    end

    // Hold lock while present and the count has reached the wait.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= det_on && reached;
    end

    // R6: lock clears on the edge after frame presence is lost.
    a_r6_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !det_on |=> !lock_q);

    // R5: lock never appears before the count reaches the wait.
    a_r5_no_early_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (det_on && (cnt_q < wait_cycles)) |=> !lock_q);

endmodule

// File: rtl/rxo_out_gate.sv
// Module: registered gating of the data bus and the output clock.
// Output enable silences both; lock silences only the data.
// Assumes oe_s and lock are synchronous to clk.
module rxo_out_gate #(
    parameter int unsigned DW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          oe_s,
    input  logic          lock,
    input  logic [DW-1:0] data_in,
    input  logic          clk_in,
    output logic [DW-1:0] data_q,
    output logic          clk_q
);

    logic data_pass;

    // Data passes only when enabled and locked.
    always_comb data_pass = oe_s && lock;

    // Register the gated data bus.
    always_ff @(posedge clk) begin
        if (!rst_n || !data_pass) data_q <= '0;
        else                      data_q <= data_in;
    end

    // Register the gated clock; lock does not affect it.
    always_ff @(posedge clk) begin
        if (!rst_n || !oe_s) clk_q <= 1'b0;
        else                 clk_q <= clk_in;
    end

    // R2: disabled output gives a static low data bus and clock.
    a_r2_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_s |=> (data_q == '0 && !clk_q));

    // R3: without lock the data is silent but the clock still follows.
    a_r3_unlocked_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_s && !lock) |=> (data_q == '0 && clk_q == $past(clk_in)));

    // R4: enabled and locked passes the bus unchanged.
    a_r4_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_s && lock) |=> (data_q == $past(data_in)));

endmodule

// File: rtl/rxo_gate_ctrl.sv
// Module: receiver output gating and status control (top).
// Synchronizes the asynchronous controls, derives the detect flags,
// runs the lock timer and gates the data bus and output clock.
// Assumes data_i and clk_i are already in the clk domain.
module rxo_gate_ctrl
    import rxo_gate_pkg::*;
#(
    parameter int unsigned DW = RXO_DATA_W_DEF,
    parameter int unsigned CW = RXO_CNT_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          oe_i,
    input  logic          frame_sense_i,
    input  logic          lane_sense_i,
    input  logic          det_en_i,
    input  logic [CW-1:0] lock_wait_i,
    input  logic [DW-1:0] data_i,
    input  logic          clk_i,
    output logic [DW-1:0] data_o,
    output logic          clk_o,
    output logic          frame_det_o,
    output logic          lane_sd_n_o,
    output logic          lock_o
);

    logic [RXO_SYNC_W-1:0] raw_v;
    logic [RXO_SYNC_W-1:0] sync_v;
    logic                  det_on;
    logic                  lock_w;

    // Collect the asynchronous controls into one vector.
    always_comb begin
        raw_v             = '0;
        raw_v[SYNC_OE]    = oe_i;
        raw_v[SYNC_FRAME] = frame_sense_i;
        raw_v[SYNC_LANE]  = lane_sense_i;
        raw_v[SYNC_DETEN] = det_en_i;
    end

    rxo_sync #(.W(RXO_SYNC_W), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_v),
        .q     (sync_v)
    );

    rxo_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_s     (sync_v[SYNC_FRAME]),
        .lane_s      (sync_v[SYNC_LANE]),
        .deten_s     (sync_v[SYNC_DETEN]),
        .det_on      (det_on),
        .frame_det_q (frame_det_o),
        .lane_sd_n_q (lane_sd_n_o)
    );

    rxo_lock_timer #(.CW(CW)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .det_on      (det_on),
        .wait_cycles (lock_wait_i),
        .lock_q      (lock_w)
    );

    rxo_out_gate #(.DW(DW)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .oe_s    (sync_v[SYNC_OE]),
        .lock    (lock_w),
        .data_in (data_i),
        .clk_in  (clk_i),
        .data_q  (data_o),
        .clk_q   (clk_o)
    );

    assign lock_o = lock_w;

    // R9: lock is reported only alongside frame detect.
    a_r9_lock_with_frame: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> frame_det_o);

    // R1: after a reset edge every output sits at its idle level.
    a_r1_reset_idle: assert property (@(posedge clk)
        disable iff (!rst_n && $isunknown(data_o))
        !rst_n |=> (data_o == '0 && !clk_o && !frame_det_o && !lock_o && lane_sd_n_o));

endmodule

// File: tb/rxo_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module rxo_gate_ctrl_tb_top;

    localparam int unsigned DW = 22;
    localparam int unsigned CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          oe_i = 1'b0;
    logic          frame_sense_i = 1'b0;
    logic          lane_sense_i = 1'b0;
    logic          det_en_i = 1'b1;
    logic [CW-1:0] lock_wait_i = '0;
    logic [DW-1:0] data_i = '0;
    logic          clk_i = 1'b0;
    logic [DW-1:0] data_o;
    logic          clk_o;
    logic          frame_det_o;
    logic          lane_sd_n_o;
    logic          lock_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rxo_gate_ctrl #(.DW(DW), .CW(CW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .oe_i          (oe_i),
        .frame_sense_i (frame_sense_i),
        .lane_sense_i  (lane_sense_i),
        .det_en_i      (det_en_i),
        .lock_wait_i   (lock_wait_i),
        .data_i        (data_i),
        .clk_i         (clk_i),
        .data_o        (data_o),
        .clk_o         (clk_o),
        .frame_det_o   (frame_det_o),
        .lane_sd_n_o   (lane_sd_n_o),
        .lock_o        (lock_o)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive just after a rising edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    // Expected steady-state outputs of one control combination.
    function automatic logic [DW+3:0] model(input logic r, input logic o,
            input logic f, input logic l, input logic e,
            input logic [DW-1:0] d, input logic c);
        logic det, lk, sdn, co;
        logic [DW-1:0] dq;
        if (!r) return {{DW{1'b0}}, 1'b0, 1'b0, 1'b1, 1'b0};
        det = e ? f : 1'b1;
        sdn = e ? ~l : 1'b0;
        lk  = det;
        dq  = (o && lk) ? d : '0;
        co  = o ? c : 1'b0;
        return {dq, co, det, sdn, lk};
    endfunction

    task automatic apply_and_check(input logic r, input logic o, input logic f,
                                   input logic l, input logic e, input string req);
        logic [DW-1:0] d;
        logic c;
        logic [DW+3:0] exp;
        d = DW'($urandom);
        c = 1'($urandom);
        rst_n = r; oe_i = o; frame_sense_i = f; lane_sense_i = l; det_en_i = e;
        data_i = d; clk_i = c;
        step(20);
        @(negedge clk);
        exp = model(r, o, f, l, e, d, c);
        check(req, "data_o", 64'(data_o), 64'(exp[DW+3:4]));
        check(req, "clk_o", 64'(clk_o), 64'(exp[3]));
        check(req, "frame_det_o", 64'(frame_det_o), 64'(exp[2]));
        check(req, "lane_sd_n_o", 64'(lane_sd_n_o), 64'(exp[1]));
        check(req, "lock_o", 64'(lock_o), 64'(exp[0]));
        check("R9", "lock without frame", 64'(lock_o && !frame_det_o), 64'd0);
    endtask

    // R5: measure edges from frame_det_o rise to lock_o rise.
    task automatic lock_delay(input int w);
        int n;
        rst_n = 1; oe_i = 1; det_en_i = 1; frame_sense_i = 0;
        step(6);
        lock_wait_i = CW'(w);
        step(1);
        frame_sense_i = 1;
        n = 0;
        while (!frame_det_o && n < 10) begin @(negedge clk); n++; end
        n = 0;
        while (!lock_o && n < 300) begin @(negedge clk); n++; end
        check("R5", "lock delay", 64'(n), 64'(w));
    endtask

    initial begin
        void'($urandom(32'h5A17));
        lock_wait_i = CW'(5);
        step(3);
        @(negedge clk);
        // R1: outputs idle while held in reset.
        check("R1", "data_o", 64'(data_o), 64'd0);
        check("R1", "clk_o", 64'(clk_o), 64'd0);
        check("R1", "frame_det_o", 64'(frame_det_o), 64'd0);
        check("R1", "lane_sd_n_o", 64'(lane_sd_n_o), 64'd1);
        check("R1", "lock_o", 64'(lock_o), 64'd0);

        // Sweep of every reset/enable/frame/lane/detect-enable combination (R1 R2 R3 R4 R7 R8).
        for (int k = 0; k < 32; k++) begin
            logic [4:0] v;
            v = 5'(k);
            apply_and_check(v[4], v[3], v[2], v[1], v[0],
                !v[4] ? "R1" : !v[3] ? "R2" : !v[0] ? "R7" : v[2] ? "R4" : "R3");
        end

        // Random combinations.
        for (int k = 0; k < 40; k++) begin
            apply_and_check(1'($urandom_range(0, 5) != 0), 1'($urandom),
                            1'($urandom), 1'($urandom), 1'($urandom), "R8");
        end

        // R5: lock timing for several waits.
        lock_delay(0);
        lock_delay(1);
        lock_delay(7);
        lock_delay(int'($urandom_range(2, 60)));

        // R6: frame loss drops detect and lock on the third edge.
        lock_wait_i = CW'(3);
        rst_n = 1; oe_i = 1; det_en_i = 1; frame_sense_i = 1;
        step(15);
        frame_sense_i = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R6", "frame_det_o after 2 edges", 64'(frame_det_o), 64'd1);
        check("R6", "lock_o after 2 edges", 64'(lock_o), 64'd1);
        @(negedge clk);
        check("R6", "frame_det_o after 3 edges", 64'(frame_det_o), 64'd0);
        check("R6", "lock_o after 3 edges", 64'(lock_o), 64'd0);

        // R3: clock keeps toggling while unlocked.
        step(3);
        for (int k = 0; k < 8; k++) begin
            logic prev;
            clk_i = ~clk_i;
            prev = clk_i;
            step(1);
            @(negedge clk);
            check("R3", "running clk_o", 64'(clk_o), 64'(prev));
            check("R3", "silent data_o", 64'(data_o), 64'd0);
        end

        // R2: disable latency of three edges.
        frame_sense_i = 1; clk_i = 1; data_i = '1;
        step(20);
        oe_i = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R2", "clk_o after 2 edges", 64'(clk_o), 64'd1);
        @(negedge clk);
        check("R2", "clk_o after 3 edges", 64'(clk_o), 64'd0);
        check("R2", "data_o after 3 edges", 64'(data_o), 64'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule